// File: doc/BRIEF.md
# Compare Match Timer

A small bank of independent up-counting timer channels behind one word-addressed register port. Each channel divides the system clock by a programmable power of two to form its tick. On every tick the channel's counter either advances by one or, when it already holds the compare value, returns to zero and raises the channel's match flag. A per-channel interrupt line follows the flag when interrupts are enabled for that channel.

Software starts and stops the channels through one shared run register, in which each bit belongs to one channel. Each channel also has three words of its own: control/status, counter and compare. The match flag is cleared by a two-step handshake. Software first reads the control word while the flag is set, then writes that word back with the flag bit at 0. A write that has no such read before it leaves the flag alone, so an event that arrives between a poll and the acknowledge is not lost.

Top module: `cmatch_timer`

## Requirements
- R1: After reset the run register reads 0, every counter reads 0, every compare register reads all ones, every control word reads 0 and every interrupt output is low.
- R2: Word address 0 is the run register. Bit n keeps channel n counting while it is 1. A write replaces all run bits at once, a stopped channel's counter does not move, and bits at or above the channel count read as 0.
- R3: Channel n's control word sits at word address 1+3n, its counter at 2+3n and its compare value at 3+3n. With 16-bit words this is byte offset 2+6n. Addresses beyond the last channel read 0 and ignore writes.
- R4: Control bits [1:0] select the tick period: codes 0, 1, 2 and 3 give one tick every 8, 32, 128 and 512 clocks. The first tick after the run bit is set lands on the clock edge that is one full period after the edge that stored the run bit.
- R5: On a tick the counter adds one, unless it equals the compare value. In that case it returns to 0 and the match flag (control bit 7) is set, so one full period is compare+1 ticks.
- R6: Clearing a run bit freezes that counter at its value. Setting the bit again restarts the tick divider from zero, so the next tick is one full period after the restart.
- R7: The control word reads back the match flag in bit 7, the interrupt enable in bit 6 and the tick select in bits [1:0]. All other bits read 0.
- R8: A control write with bit 7 at 0 clears the flag only if a control read has seen the flag at 1 since it was last set. Writing 1 to bit 7 never changes the flag, and a clear write with no such read before it has no effect.
- R9: A channel's interrupt output is high exactly while its match flag and its interrupt enable are both 1. It stays high until the flag is cleared or the enable is written to 0.
- R10: A counter write in the same cycle as a tick stores the written value. That tick is lost and cannot set the flag.
- R11: With compare at all ones the counter passes through its top value and wraps to 0, and the flag is set only on that wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; arms a flag clear when it hits a control word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed word, combinational |
| irq | output | NUM_CH | Per-channel interrupt, flag AND enable |

## Verification
The hardest situation to reach is a counter write that lands on exactly the clock edge where the divider issues a tick. The same alignment problem arises for a restart, where the only sign that the divider was reset is the absence of a tick it would otherwise have produced. The bench keeps a free-running cycle count and records it on the edge that stores each run bit. It then waits until a chosen offset from that edge before it issues the next write or read. This places strobes on known tick edges, and every expected counter value comes straight from the elapsed cycles divided by the tick period, taken modulo compare+1.

// File: rtl/cmatch_pkg.sv
package cmatch_pkg;

    // Tick select field width and divider law: period = 2**(BASE + STEP*code)
    localparam int CKS_W        = 2;
    localparam int DIV_BASE_LOG = 3;
    localparam int DIV_STEP_LOG = 2;
    localparam int PRE_W_MIN    = DIV_BASE_LOG + DIV_STEP_LOG * ((1 << CKS_W) - 1);

    // Control word bit positions
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;

    // Words per channel and their order inside a channel group
    localparam int REGS_PER_CH = 3;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CNT  = 2'd1,
        REG_CMP  = 2'd2
    } chan_reg_e;

    function automatic int unsigned div_log2(input logic [CKS_W-1:0] code);
        return DIV_BASE_LOG + DIV_STEP_LOG * int'(code);
    endfunction

endpackage

// File: rtl/cmatch_prescale.sv
module cmatch_prescale
    import cmatch_pkg::*;
#(
    parameter int PRE_W = PRE_W_MIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = PRE_W'((32'd1 << div_log2(cks)) - 32'd1);
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.pre = '0;
        end else if (st_q.pre >= lim) begin
            st_d.pre = '0;
            tick     = 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cmatch_channel.sv
module cmatch_channel
    import cmatch_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_ctrl,
    input  logic              wr_cnt,
    input  logic              wr_cmp,
    input  logic              rd_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] cmp,
    output logic              flag,
    output logic              tick,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] cmp;
        logic              flag;
        logic              armed;
        logic              ie;
        logic [CKS_W-1:0]  cks;
    } ch_st_t;

    localparam ch_st_t CH_RESET = '{
        cnt:   '0,
        cmp:   '1,
        flag:  1'b0,
        armed: 1'b0,
        ie:    1'b0,
        cks:   '0
    };

    ch_st_t st_d, st_q;
    logic   hit;

    cmatch_prescale #(
        .PRE_W (PRE_W_MIN)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .cks   (st_q.cks),
        .tick  (tick)
    );

    always_comb begin
        st_d = st_q;
        hit  = tick && (st_q.cnt == st_q.cmp) && !wr_cnt;

        // counter: tick advances or wraps, a bus write overrides
        if (tick) begin
            st_d.cnt = (st_q.cnt == st_q.cmp) ? '0 : st_q.cnt + 1'b1;
        end
        if (wr_cnt) begin
            st_d.cnt = wdata;
        end
        if (wr_cmp) begin
            st_d.cmp = wdata;
        end

        // clear handshake: a read that sees the flag arms the clear
        if (rd_ctrl && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (wr_ctrl) begin
            st_d.ie  = wdata[IE_BIT];
            st_d.cks = wdata[CKS_W-1:0];
            if (!wdata[FLAG_BIT] && st_q.armed) begin
                st_d.flag  = 1'b0;
                st_d.armed = 1'b0;
            end
        end

        // a new match wins over a clear and needs a fresh read
        if (hit) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[FLAG_BIT]      = st_q.flag;
        ctrl_word[IE_BIT]        = st_q.ie;
        ctrl_word[CKS_W-1:0]     = st_q.cks;
    end

    assign cnt  = st_q.cnt;
    assign cmp  = st_q.cmp;
    assign flag = st_q.flag;
    assign irq  = st_q.flag & st_q.ie;

endmodule

// File: rtl/cmatch_timer.sv
module cmatch_timer
    import cmatch_pkg::*;
#(
    parameter  int NUM_CH    = 2,
    parameter  int DATA_W    = 16,
    localparam int NUM_WORDS = 1 + REGS_PER_CH * NUM_CH,
    localparam int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] run;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                           start_hit;
    logic [NUM_CH-1:0]              run_q;
    logic [NUM_CH-1:0]              sel_ctrl, sel_cnt, sel_cmp;
    logic [NUM_CH-1:0]              tick_w, flag_w;
    logic [NUM_CH-1:0][DATA_W-1:0]  ctrl_w, cnt_w, cmp_w;

    assign start_hit = (bus_addr == ADDR_W'(0));
    assign run_q     = st_q.run;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            localparam int BASE = 1 + REGS_PER_CH * i;

            assign sel_ctrl[i] = (bus_addr == ADDR_W'(BASE + int'(REG_CTRL)));
            assign sel_cnt[i]  = (bus_addr == ADDR_W'(BASE + int'(REG_CNT)));
            assign sel_cmp[i]  = (bus_addr == ADDR_W'(BASE + int'(REG_CMP)));

            cmatch_channel #(
                .DATA_W (DATA_W)
            ) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (run_q[i]),
                .wr_ctrl   (bus_wr & sel_ctrl[i]),
                .wr_cnt    (bus_wr & sel_cnt[i]),
                .wr_cmp    (bus_wr & sel_cmp[i]),
                .rd_ctrl   (bus_rd & sel_ctrl[i]),
                .wdata     (bus_wdata),
                .ctrl_word (ctrl_w[i]),
                .cnt       (cnt_w[i]),
                .cmp       (cmp_w[i]),
                .flag      (flag_w[i]),
                .tick      (tick_w[i]),
                .irq       (irq[i])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (bus_wr && start_hit) begin
            st_d.run = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (start_hit) begin
            bus_rdata = DATA_W'(st_q.run);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_ctrl[i]) bus_rdata = ctrl_w[i];
            if (sel_cnt[i])  bus_rdata = cnt_w[i];
            if (sel_cmp[i])  bus_rdata = cmp_w[i];
        end
    end

endmodule

// File: rtl/cmatch_timer_chk.sv
module cmatch_timer_chk #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic [NUM_CH-1:0]             irq,
    input logic [NUM_CH-1:0]             run_q,
    input logic [NUM_CH-1:0]             tick_w,
    input logic [NUM_CH-1:0][DATA_W-1:0] cnt_w,
    input logic [NUM_CH-1:0][DATA_W-1:0] cmp_w,
    input logic [NUM_CH-1:0]             flag_w
);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R2
            stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_q[i] && !bus_wr) |=> $stable(cnt_w[i]));

            // R5
            wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_w[i] && (cnt_w[i] == cmp_w[i]) && !bus_wr) |=> ((cnt_w[i] == '0) && flag_w[i]));

            // R5
            step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_w[i] && (cnt_w[i] != cmp_w[i]) && !bus_wr) |=> (cnt_w[i] == DATA_W'($past(cnt_w[i]) + 1'b1)));

            // R5
            flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_w[i]) |-> $past(tick_w[i]));

            // R9
            irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(irq[i]) |-> $past(bus_wr));
        end
    endgenerate

endmodule

bind cmatch_timer cmatch_timer_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_wr (bus_wr),
    .irq    (irq),
    .run_q  (run_q),
    .tick_w (tick_w),
    .cnt_w  (cnt_w),
    .cmp_w  (cmp_w),
    .flag_w (flag_w)
);

// File: tb/cmatch_timer_bench.sv
`timescale 1ns/1ps
module cmatch_timer_bench;

    localparam int NCH = 2;
    localparam int DW  = 16;
    localparam int AW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] irq;

    int ntests = 0;
    int nfail  = 0;
    int cyc    = 0;
    int ref_c  = 0;
    bit done   = 0;

    cmatch_timer #(.NUM_CH(NCH), .DATA_W(DW)) u_cmatch_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int a_ctrl(int c); return 1 + 3 * c; endfunction
    function automatic int a_cnt(int c);  return 2 + 3 * c; endfunction
    function automatic int a_cmp(int c);  return 3 + 3 * c; endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        bus_addr  = a[AW-1:0];
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        bus_addr = a[AW-1:0];
        bus_rd   = 1'b1;
        #1 d     = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_until(input int k);
        while (cyc - ref_c < k) @(negedge clk);
    endtask

    // read-then-write acknowledge, leaving ie/cks as given
    task automatic ack(input int c, input logic [DW-1:0] keep);
        logic [DW-1:0] v;
        rd(a_ctrl(c), v);
        wr(a_ctrl(c), keep);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v);            chk("R1 run reg", v, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(a_ctrl(c), v); chk("R1 ctrl", v, 0);
            rd(a_cnt(c), v);  chk("R1 cnt", v, 0);
            rd(a_cmp(c), v);  chk("R1 cmp", v, 16'hFFFF);
        end
        chk("R1 irq", irq, 0);

        // R3 address map and unmapped word
        wr(a_cmp(1), 16'h1234);
        rd(a_cmp(1), v);     chk("R3 ch1 cmp", v, 16'h1234);
        rd(a_cmp(0), v);     chk("R3 ch0 cmp untouched", v, 16'hFFFF);
        wr(7, 16'hAAAA);
        rd(7, v);            chk("R3 unmapped read", v, 0);
        rd(a_cnt(1), v);     chk("R3 unmapped write ignored", v, 0);

        // R2 run register width
        wr(0, 16'hFFFF);
        rd(0, v);            chk("R2 run readback", v, 16'h0003);
        wr(0, 16'h0000);

        // R7 R8 control field layout; writing 1 to flag does nothing
        wr(a_ctrl(0), 16'hFFFF);
        rd(a_ctrl(0), v);    chk("R7 R8 ctrl fields", v, 16'h0043);
        wr(a_ctrl(0), 16'h0000);

        // R4 R5 sweep over tick selects
        for (int c = 0; c < 4; c++) begin
            int d;
            d = 1 << (3 + 2 * c);
            wr(0, 0);
            ack(0, 16'(c));
            wr(a_cnt(0), 0);
            wr(a_cmp(0), 4);
            wr(0, 1);
            ref_c = cyc;
            for (int m = 0; m < 8; m++) begin
                wait_until(d * m + 3);
                rd(a_cnt(0), v);   chk("R4 R5 count", v, m % 5);
                rd(a_ctrl(0), v);
                chk("R5 flag", v[7], (m >= 5));
                chk("R7 cks", v[1:0], c);
            end
            rd(a_cnt(1), v);       chk("R2 idle channel", v, 0);
        end

        // R6 stop holds, restart resets the divider
        wr(0, 0);
        ack(0, 16'h0000);
        wr(a_cnt(0), 0);
        wr(a_cmp(0), 16'hFFFF);
        wr(0, 1);
        ref_c = cyc;
        wait_until(29);
        wr(0, 0);
        held = (cyc - ref_c) / 8;
        rd(a_cnt(0), v);     chk("R6 stop value", v, held);
        repeat (40) @(negedge clk);
        rd(a_cnt(0), v);     chk("R6 held", v, held);
        wr(0, 1);
        ref_c = cyc;
        wait_until(7);
        rd(a_cnt(0), v);     chk("R6 divider restarted", v, held);
        wait_until(9);
        rd(a_cnt(0), v);     chk("R6 first tick after restart", v, held + 1);

        // R10 counter write on a tick edge
        wr(0, 0);
        wr(a_cnt(0), 0);
        wr(0, 1);
        ref_c = cyc;
        wait_until(15);
        wr(a_cnt(0), 16'h0100);
        rd(a_cnt(0), v);     chk("R10 write wins", v, 16'h0100);
        wait_until(25);
        rd(a_cnt(0), v);     chk("R10 next tick", v, 16'h0101);

        // R11 full range wrap
        wr(0, 0);
        ack(0, 16'h0000);
        wr(a_cmp(0), 16'hFFFF);
        wr(a_cnt(0), 16'hFFFD);
        wr(0, 1);
        ref_c = cyc;
        wait_until(20);
        rd(a_cnt(0), v);     chk("R11 top value", v, 16'hFFFF);
        rd(a_ctrl(0), v);    chk("R11 no flag before wrap", v[7], 0);
        wait_until(28);
        rd(a_cnt(0), v);     chk("R11 wrapped", v, 0);
        rd(a_ctrl(0), v);    chk("R11 flag on wrap", v[7], 1);
        wr(0, 0);

        // R8 R9 interrupt handshake on channel 1
        wr(a_ctrl(1), 16'h0040);
        wr(a_cnt(1), 0);
        wr(a_cmp(1), 2);
        wr(0, 2);
        ref_c = cyc;
        wait_until(20);
        chk("R9 irq before match", irq[1], 0);
        wait_until(26);
        chk("R9 irq on match", irq[1], 1);
        chk("R9 other channel quiet", irq[0], 0);
        wr(0, 0);
        wr(a_ctrl(1), 16'h0040);
        chk("R8 clear without read ignored", irq[1], 1);
        rd(a_ctrl(1), v);    chk("R7 ctrl with flag", v, 16'h00C0);
        wr(a_ctrl(1), 16'h00C0);
        chk("R8 writing one keeps flag", irq[1], 1);
        wr(a_ctrl(1), 16'h0040);
        chk("R8 armed clear", irq[1], 0);
        rd(a_ctrl(1), v);    chk("R8 flag cleared", v, 16'h0040);

        // R9 enable gates the interrupt
        wr(a_ctrl(1), 16'h0000);
        wr(a_cnt(1), 0);
        wr(0, 2);
        ref_c = cyc;
        wait_until(26);
        chk("R9 masked", irq[1], 0);
        rd(a_ctrl(1), v);    chk("R9 flag set while masked", v[7], 1);
        wr(0, 0);
        wr(a_ctrl(1), 16'h00C0);
        chk("R9 enable raises irq", irq[1], 1);

        done = 1;
        summary();
        $finish;
    end

endmodule